// File: doc/BRIEF.md
# Run-Length Strategy Index Decoder

The block watches a non-return-to-zero data line sampled once per run-length clock, measures how many clock periods each level lasts, and classifies every completed run as a mark (write) run or a space (erase) run. From the length of the run that just ended and the length of the run before it, it forms a 6-bit index into a 64-entry write-strategy table. Some mark/space length pairs get their own table entries, which a pulse generator downstream can use for precompensation. A run that lasts 16 periods or more is treated as an end of writing: the block enters a read state and reports index 0.

Every result passes through a delay line, so each index leaves the block a fixed number of clocks after the data edge that closed its run, whatever the run length. Two mode inputs change how the data is read. A forced-erase input ignores the data and holds the decoder in erase. A sensitivity input chooses between classifying runs by their level and classifying them purely by edge alternation.

Top module: `runlen_lookback_dec`

## Requirements
- R1: Each run that starts with a sampled edge and ends with the next sampled edge gives exactly one strobe. The strobe (`strat_vld` high for one cycle) follows LATENCY (default 28) rising edges after the edge that samples the first bit of the next run. No other strobes occur.
- R2: A space run of length 1 or 2 gives index 1 or 2. A space run of length L from 6 to 15 gives index L+8 (14 to 23).
- R3: A space run of length 3 gives 3, 4 or 5 when the mark run before it had length 3, 4 or 5, and 6 otherwise. Length 4 gives 7, 8, 9 under the same condition and 10 otherwise. Length 5 gives 11 or 12 after a mark run of 3 or 4, and 13 otherwise.
- R4: A mark run of length L from 1 to 5 gives 24+6*(L-1)+(P-1) when the space run before it had a length P from 1 to 5, and 24+6*(L-1)+5 otherwise. A mark run of length L from 6 to 15 gives L+48.
- R5: When 16 consecutive samples are equal and the decoder is not already in read, it gives one strobe with index 0 and read flag 1, LATENCY edges after the 16th sample. No further strobe follows until a run has been closed after the next edge. The run that ends the read state is not reported, and the next run has no predecessor for look-back.
- R6: With `edge_only` low, a run at level 1 is a mark and a run at level 0 is a space.
- R7: With `edge_only` high, the type of a run depends only on edges. The first run after the read state or forced erase is a mark whatever its level, and after that the types alternate.
- R8: While `force_erase` is high, data edges produce no strobes, the read flag is driven low LATENCY edges after `force_erase` is first sampled, the run in progress is discarded, and look-back history is cleared.
- R9: After reset, `strat_vld` is 0, `strat_idx` is 0 and `read_flag` is 1. The run that ends with the first edge after reset is not reported.
- R10: `strat_idx` is 0 whenever `strat_vld` is low.
- R11: `read_flag` is low on every strobe of a mark or space run. It rises only together with a read strobe, and it never falls during a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Run-length clock |
| rst | input | 1 | Synchronous active-high reset |
| rl_data | input | 1 | NRZ data, sampled on each rising edge |
| force_erase | input | 1 | Ignore data and hold the decoder in erase |
| edge_only | input | 1 | 1: classify runs by edge alternation, 0: by level |
| strat_idx | output | 6 | Strategy table index, 0 when no strobe |
| strat_vld | output | 1 | One-cycle strobe marking a valid index |
| read_flag | output | 1 | 1 in read state, 0 while writing or erasing |

## Verification
The bench numbers the rising edges. When it drives the first bit of a run, it files the index of the run just closed as due at that bit's sampling edge plus LATENCY. A read event is filed as due LATENCY edges after the 16th equal sample. A monitor looks at the outputs on every falling edge and requires a strobe exactly when the oldest expected item falls due, so a strobe that comes early, comes late or should not exist is caught. For forced erase, the read flag is sampled on the falling edge just before and just after the edge that lies LATENCY edges past the first sampled assertion of `force_erase`.

// File: rtl/rld_pkg.sv
package rld_pkg;

  localparam int unsigned IDX_W = 6;
  localparam int unsigned LEN_W = 4;
  localparam int unsigned CNT_W = 5;

  typedef struct packed {
    logic             vld;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } rld_out_t;

  // Strategy index from (type, length) of the closed run and its predecessor.
  function automatic logic [IDX_W-1:0] strat_index(
    input logic             is_mark,
    input logic [LEN_W-1:0] len,
    input logic             prev_ok,
    input logic [LEN_W-1:0] plen
  );
    logic [IDX_W-1:0] l6;
    logic [IDX_W-1:0] p6;
    logic [IDX_W-1:0] r;
    l6 = {2'b00, len};
    p6 = {2'b00, plen};
    if (is_mark) begin
      if (len <= 4'd5) begin
        r = 6'd24 + 6'd6 * (l6 - 6'd1);
        if (prev_ok && (plen >= 4'd1) && (plen <= 4'd5)) r = r + p6 - 6'd1;
        else                                               r = r + 6'd5;
      end else begin
        r = l6 + 6'd48;
      end
    end else begin
      case (len)
        4'd1, 4'd2: r = l6;
        4'd3: r = (prev_ok && plen >= 4'd3 && plen <= 4'd5) ? p6 : 6'd6;
        4'd4: r = (prev_ok && plen >= 4'd3 && plen <= 4'd5) ? p6 + 6'd4 : 6'd10;
        4'd5: r = (prev_ok && plen >= 4'd3 && plen <= 4'd4) ? p6 + 6'd8 : 6'd13;
        default: r = l6 + 6'd8;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rld_run_meter.sv
module rld_run_meter
  import rld_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             force_erase,
  input  logic             edge_only,
  output logic             ev_vld,
  output logic             ev_read,
  output logic             ev_clr,
  output logic             ev_mark,
  output logic [LEN_W-1:0] ev_len,
  output logic             rd_now
);

  localparam logic [CNT_W-1:0] READ_AT = CNT_W'(16);
  localparam logic [CNT_W-1:0] LAST_OK = CNT_W'(15);

  logic             d_q, d_prev, fe_q;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             blind, blind_n;   // current run has no known start
  logic             rd_st;
  logic             mark_t, mark_n;   // type of current run in edge-only mode
  logic             trans;

  assign trans = d_q ^ d_prev;

  always_comb begin
    cnt_n   = cnt;
    blind_n = blind;
    rd_now  = rd_st;
    mark_n  = mark_t;
    ev_vld  = 1'b0;
    ev_read = 1'b0;
    ev_clr  = 1'b0;
    ev_mark = edge_only ? mark_t : d_prev;
    ev_len  = cnt[LEN_W-1:0];
    if (fe_q) begin
      cnt_n   = '0;
      blind_n = 1'b1;
      rd_now  = 1'b0;
      ev_clr  = 1'b1;
    end else if (trans) begin
      cnt_n   = CNT_W'(1);
      blind_n = 1'b0;
      rd_now  = 1'b0;
      mark_n  = blind ? 1'b1 : ~mark_t;
      ev_vld  = ~blind;
    end else begin
      cnt_n = (cnt == READ_AT) ? READ_AT : cnt + CNT_W'(1);
      if ((cnt == LAST_OK) && !rd_st) begin
        ev_read = 1'b1;
        ev_clr  = 1'b1;
        blind_n = 1'b1;
        rd_now  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q    <= 1'b0;
      d_prev <= 1'b0;
      fe_q   <= 1'b0;
      cnt    <= '0;
      blind  <= 1'b1;
      rd_st  <= 1'b1;
      mark_t <= 1'b1;
    end else begin
      d_q    <= din;
      d_prev <= d_q;
      fe_q   <= force_erase;
      cnt    <= cnt_n;
      blind  <= blind_n;
      rd_st  <= rd_now;
      mark_t <= mark_n;
    end
  end

endmodule

// File: rtl/rld_index_map.sv
module rld_index_map
  import rld_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_vld,
  input  logic             ev_read,
  input  logic             ev_clr,
  input  logic             ev_mark,
  input  logic [LEN_W-1:0] ev_len,
  input  logic             rd_now,
  output rld_out_t         ev_q
);

  logic             prev_ok;
  logic [LEN_W-1:0] plen;
  rld_out_t         nx;

  always_comb begin
    nx.rd  = rd_now;
    nx.vld = ev_vld | ev_read;
    nx.idx = '0;
    if (ev_vld) nx.idx = strat_index(ev_mark, ev_len, prev_ok, plen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q    <= '{vld: 1'b0, rd: 1'b1, idx: '0};
      prev_ok <= 1'b0;
      plen    <= '0;
    end else begin
      ev_q <= nx;
      if (ev_vld) begin
        prev_ok <= 1'b1;
        plen    <= ev_len;
      end else if (ev_clr) begin
        prev_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rld_delay_line.sv
module rld_delay_line #(
  parameter int unsigned         W       = 8,
  parameter int unsigned         DEPTH   = 27,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign d_out = d_in;
    end else begin : g_shift
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d_in;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign d_out = stg[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/runlen_lookback_dec.sv
module runlen_lookback_dec
  import rld_pkg::*;
#(
  parameter int unsigned LATENCY = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rl_data,
  input  logic             force_erase,
  input  logic             edge_only,
  output logic [IDX_W-1:0] strat_idx,
  output logic             strat_vld,
  output logic             read_flag
);

  localparam int unsigned   OUT_W  = $bits(rld_out_t);
  localparam int unsigned   DEPTH  = (LATENCY > 2) ? LATENCY - 1 : 1;
  localparam rld_out_t      IDLE   = '{vld: 1'b0, rd: 1'b1, idx: '0};

  logic             ev_vld, ev_read, ev_clr, ev_mark, rd_now;
  logic [LEN_W-1:0] ev_len;
  rld_out_t         ev_q, out_s;
  logic [OUT_W-1:0] out_v;

  rld_run_meter u_meter (
    .clk(clk), .rst(rst), .din(rl_data), .force_erase(force_erase),
    .edge_only(edge_only), .ev_vld(ev_vld), .ev_read(ev_read),
    .ev_clr(ev_clr), .ev_mark(ev_mark), .ev_len(ev_len), .rd_now(rd_now)
  );

  rld_index_map u_map (
    .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev_read(ev_read),
    .ev_clr(ev_clr), .ev_mark(ev_mark), .ev_len(ev_len),
    .rd_now(rd_now), .ev_q(ev_q)
  );

  rld_delay_line #(.W(OUT_W), .DEPTH(DEPTH), .RST_VAL(IDLE)) u_dly (
    .clk(clk), .rst(rst), .d_in(ev_q), .d_out(out_v)
  );

  assign out_s     = rld_out_t'(out_v);
  assign strat_idx = out_s.idx;
  assign strat_vld = out_s.vld;
  assign read_flag = out_s.rd;

endmodule

// File: rtl/rld_checker.sv
module rld_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] strat_idx,
  input logic       strat_vld,
  input logic       read_flag
);

  // R5: a strobe in read state carries index 0
  a_r5_read_idx_zero: assert property (@(posedge clk) disable iff (rst)
    (strat_vld && read_flag) |-> (strat_idx == 6'd0));

  // R11: strobes of real runs come with the read flag low and a nonzero index
  a_r11_write_idx_nonzero: assert property (@(posedge clk) disable iff (rst)
    (strat_vld && !read_flag) |-> (strat_idx != 6'd0));

  // R10: idle outputs read as zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !strat_vld |-> (strat_idx == 6'd0));

  // R11: the read flag rises only together with the read strobe
  a_r11_rise_with_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(read_flag) |-> strat_vld);

  // R11: leaving read never coincides with a strobe
  a_r11_fall_no_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(read_flag) |-> !strat_vld);

endmodule

bind runlen_lookback_dec rld_checker u_chk (
  .clk(clk), .rst(rst), .strat_idx(strat_idx),
  .strat_vld(strat_vld), .read_flag(read_flag)
);

// File: tb/sim_runlen_lookback_dec.sv
module sim_runlen_lookback_dec;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic       fe  = 1'b0;
  logic       eo  = 1'b0;
  logic [5:0] idx;
  logic       vld, rf;

  runlen_lookback_dec #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst(rst), .rl_data(din), .force_erase(fe),
    .edge_only(eo), .strat_idx(idx), .strat_vld(vld), .read_flag(rf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct { int due; int ix; bit rd; string req; } exp_t;
  exp_t q[$];

  // bench model of the requirements
  bit blind = 1, have_prev = 0, cur_mark = 1;
  int cur_len = 0, plen = 0;

  function automatic int want_idx(bit mark, int len, bit hp, int pl);
    if (mark) begin
      if (len >= 6) return 48 + len;
      return 24 + 6 * (len - 1) + ((hp && pl >= 1 && pl <= 5) ? pl - 1 : 5);
    end
    if (len <= 2) return len;
    if (len >= 6) return len + 8;
    if (len == 3) return (hp && pl >= 3 && pl <= 5) ? pl : 6;
    if (len == 4) return (hp && pl >= 3 && pl <= 5) ? pl + 4 : 10;
    return (hp && pl >= 3 && pl <= 4) ? pl + 8 : 13;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int due, int ix, bit r, string req);
    exp_t e;
    e.due = due; e.ix = ix; e.rd = r; e.req = req;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(vld == 1'b1, {e.req, " strobe R1"}, int'(vld), 1);
        check(idx == e.ix, {e.req, " index"}, int'(idx), e.ix);
        check(rf == e.rd,  {e.req, " read flag R11"}, int'(rf), int'(e.rd));
      end else if (vld) begin
        check(1'b0, "R1 unexpected strobe, index", int'(idx), -1);
      end
    end
  end

  // drive one run; files the closed predecessor and any read event
  task automatic run(bit lvl, int len, string pfx);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        int s;
        string tag;
        s = cyc + 1;
        if (!blind) begin
          tag = cur_mark ? "R4" : ((cur_len >= 3 && cur_len <= 5) ? "R3" : "R2");
          push(s + LAT, want_idx(cur_mark, cur_len, have_prev, plen), 1'b0, {pfx, tag});
          have_prev = 1;
          plen      = cur_len;
          cur_mark  = eo ? ~cur_mark : lvl;
        end else begin
          cur_mark  = eo ? 1'b1 : lvl;
        end
        blind   = 0;
        cur_len = len;
        if (len >= 16) begin
          push(s + 15 + LAT, 0, 1'b1, {pfx, "R5"});
          blind     = 1;
          have_prev = 0;
        end
      end
      din = lvl;
    end
  endtask

  // forced erase during read, with data toggling underneath (R8)
  task automatic fe_hold();
    int f;
    @(negedge clk);
    fe = 1'b1;
    f  = cyc + 1;
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      if (k < LAT && (k % 2 == 0)) din = ~din;
      if (cyc == f + LAT - 1) check(rf == 1'b1, "R8 read flag before forced erase reaches output", int'(rf), 1);
      if (cyc == f + LAT)     check(rf == 1'b0 && vld == 1'b0, "R8 read flag low under forced erase", int'(rf), 0);
    end
    fe        = 1'b0;
    blind     = 1;
    have_prev = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  int lens[38] = '{3,4,2,5,1,3,6,1,15,15,4,8,5,2,3,5,4,5,5,5,
                   3,3,4,4,5,4,2,7,1,6,9,11,12,13,14,10,3,3};

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check(vld == 1'b0, "R9 strobe after reset", int'(vld), 0);
    check(idx == 6'd0, "R9 index after reset", int'(idx), 0);
    check(rf  == 1'b1, "R9 read flag after reset", int'(rf), 1);
    repeat (3) @(negedge clk);

    // R6 level mode: first run after reset is unreported, then all length pairs
    for (int i = 0; i < 38; i++) run((i % 2) == 0, lens[i], "R6 ");
    run(1'b1, 20, "R5 ");           // long run enters read

    fe_hold();                       // R8
    run(1'b0, 2, "R6 ");             // closes the blind run, no report
    run(1'b1, 3, "R6 ");             // space 2 without predecessor
    run(1'b0, 3, "R6 ");
    run(1'b1, 2, "R6 ");
    run(1'b0, 4, "R6 ");
    run(1'b1, 20, "R5 ");

    // R7 edge-only: first run after read is a mark even at level 0
    eo = 1'b1;
    run(1'b0, 3, "R7 ");
    run(1'b1, 4, "R7 ");
    run(1'b0, 2, "R7 ");
    run(1'b1, 1, "R7 ");
    run(1'b0, 20, "R7 ");
    run(1'b1, 2, "R7 ");
    run(1'b0, 3, "R7 ");
    run(1'b1, 5, "R7 ");
    run(1'b0, 20, "R7 ");

    repeat (LAT + 6) @(negedge clk);
    check(q.size() == 0, "R1 all expected strobes seen", q.size(), 0);
    finish_up();
  end

endmodule